// File: doc/BRIEF.md
# I2C Bus Event Status Flags

This block observes the serial clock and data lines of an I2C bus, after they pass a two-flop synchroniser, and recognises the three framing conditions: START, repeated START and STOP. From those conditions and a handful of controller status strobes, it keeps four raw event flags. These flags are consumed by an interrupt mask and a register file elsewhere in the controller.

A STOP does not always raise its flag. Two configuration bits decide when it does. In slave mode, one bit can require that this device's own programmed address was matched during the transfer; a transfer reached only through the general-call address does not count. In master mode, the other bit can require that the master engine is active when the STOP appears. A sticky activity flag records that the bus was in use. It stays set until software, a disable or a reset clears it. A done flag records a not-acknowledged byte while the device acts as slave-transmitter.

Top module: `i2c_bus_evt_status`

## Requirements
- R1: After a synchronous reset, all four flags in `raw_evt` read 0.
- R2: An SDA fall while SCL is high (START or repeated START) sets `raw_evt[10]` in either mode. The flag is visible after the third rising clock edge following the line change.
- R3: An SDA change while SCL is low sets neither `raw_evt[10]` nor `raw_evt[9]`.
- R4: With `master_mode`=0 and `cfg_stop_if_addr`=1, a STOP (SDA rise while SCL high) sets `raw_evt[9]` only if `sar_match` pulsed since the previous STOP. An address reached through general call alone does not set it.
- R5: With `master_mode`=0 and `cfg_stop_if_addr`=0, every STOP sets `raw_evt[9]`.
- R6: With `master_mode`=1 and `cfg_stop_if_mst_act`=1, a STOP sets `raw_evt[9]` only while `master_active`=1. With that bit at 0, every STOP sets it.
- R7: `raw_evt[8]` (activity) is set by a START and while the bus is busy. It stays set after the bus returns idle.
- R8: Activity is cleared one edge after any of these: `ctl_enable`=0, a `rd_clr_activity` pulse, a `rd_clr_intr` pulse, or reset. `rd_clr_activity` leaves the other flags unchanged.
- R9: A `slv_tx_nack` pulse sets `raw_evt[7]` (done) at the next clock edge.
- R10: A `rd_clr_intr` pulse clears `raw_evt[10]`, `raw_evt[9]` and `raw_evt[7]` at the next edge. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Oversampled SCL line |
| sda_in | input | 1 | Oversampled SDA line |
| ctl_enable | input | 1 | Controller enable; low clears activity |
| master_mode | input | 1 | 1 = controller acts as master, 0 = slave |
| sar_match | input | 1 | Pulse: programmed slave address matched |
| master_active | input | 1 | Master engine currently active |
| slv_tx_nack | input | 1 | Pulse: master did not acknowledge a byte sent by this slave |
| cfg_stop_if_addr | input | 1 | Slave STOP flag only when addressed |
| cfg_stop_if_mst_act | input | 1 | Master STOP flag only when master active |
| rd_clr_activity | input | 1 | Read strobe of the activity clear register |
| rd_clr_intr | input | 1 | Read strobe of the combined clear register |
| raw_evt | output | 4 | [10] start, [9] stop, [8] activity, [7] done |

## Verification
Line-derived flags (start, stop, and activity raised by a START) are due on the third rising edge after the bench changes a line. Two edges go to the synchroniser and one to the flag register. Strobe-driven results (done, every clear) are due on the first edge. The bench drives on falling edges and samples on falling edges after exactly that many rising edges. For the START path it also checks that the flag is still low one edge earlier. Stops are issued with several idle cycles around each line change, so no check falls inside the synchroniser delay.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

    localparam int BIT_START = 10;
    localparam int BIT_STOP  = 9;
    localparam int BIT_ACT   = 8;
    localparam int BIT_DONE  = 7;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lines_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic activity;
        logic done;
    } evt_stat_t;

    localparam bus_lines_t LINES_IDLE = '{scl: 1'b1, sda: 1'b1};

    function automatic logic stop_allowed(
        input logic master_mode,
        input logic cfg_if_addr,
        input logic cfg_if_mst,
        input logic addressed,
        input logic mst_active
    );
        if (master_mode)
            return cfg_if_mst ? mst_active : 1'b1;
        else
            return cfg_if_addr ? addressed : 1'b1;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_lines_t raw,
    output bus_lines_t cur,
    output bus_lines_t prev
);
    localparam int CHAIN = SYNC_STAGES + 1;

    bus_lines_t chain_q [CHAIN];

    genvar g;
    generate
        for (g = 0; g < CHAIN; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain_q[g] <= LINES_IDLE;
                else if (g == 0)
                    chain_q[g] <= raw;
                else
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign cur  = chain_q[SYNC_STAGES - 1];
    assign prev = chain_q[SYNC_STAGES];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_lines_t cur,
    input  bus_lines_t prev,
    output logic       start_pulse,
    output logic       stop_pulse,
    output logic       bus_busy
);
    logic scl_held_high;
    logic busy_q;

    assign scl_held_high = cur.scl & prev.scl;
    assign start_pulse   = scl_held_high & prev.sda & ~cur.sda;
    assign stop_pulse    = scl_held_high & ~prev.sda & cur.sda;

    always_ff @(posedge clk) begin
        if (rst)
            busy_q <= 1'b0;
        else if (start_pulse)
            busy_q <= 1'b1;
        else if (stop_pulse)
            busy_q <= 1'b0;
    end

    assign bus_busy = busy_q;
endmodule

// File: rtl/i2c_stop_qual.sv
module i2c_stop_qual
    import i2c_evt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stop_pulse,
    input  logic sar_match,
    input  logic master_mode,
    input  logic master_active,
    input  logic cfg_stop_if_addr,
    input  logic cfg_stop_if_mst_act,
    output logic stop_ok
);
    logic addressed_q;

    always_ff @(posedge clk) begin
        if (rst)
            addressed_q <= 1'b0;
        else if (stop_pulse)
            addressed_q <= 1'b0;
        else if (sar_match)
            addressed_q <= 1'b1;
    end

    assign stop_ok = stop_pulse & stop_allowed(master_mode, cfg_stop_if_addr,
                                               cfg_stop_if_mst_act, addressed_q,
                                               master_active);
endmodule

// File: rtl/i2c_evt_flags.sv
module i2c_evt_flags
    import i2c_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_pulse,
    input  logic      stop_ok,
    input  logic      bus_busy,
    input  logic      slv_tx_nack,
    input  logic      ctl_enable,
    input  logic      rd_clr_activity,
    input  logic      rd_clr_intr,
    output evt_stat_t flags
);
    evt_stat_t flags_q;
    evt_stat_t flags_d;
    logic      act_keep;

    assign act_keep = flags_q.activity & ~rd_clr_activity & ~rd_clr_intr;

    always_comb begin
        flags_d.start    = start_pulse | (flags_q.start & ~rd_clr_intr);
        flags_d.stop     = stop_ok     | (flags_q.stop  & ~rd_clr_intr);
        flags_d.done     = slv_tx_nack | (flags_q.done  & ~rd_clr_intr);
        flags_d.activity = ctl_enable & (start_pulse | bus_busy | act_keep);
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/i2c_bus_evt_status.sv
module i2c_bus_evt_status
    import i2c_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_in,
    input  logic        sda_in,
    input  logic        ctl_enable,
    input  logic        master_mode,
    input  logic        sar_match,
    input  logic        master_active,
    input  logic        slv_tx_nack,
    input  logic        cfg_stop_if_addr,
    input  logic        cfg_stop_if_mst_act,
    input  logic        rd_clr_activity,
    input  logic        rd_clr_intr,
    output logic [10:7] raw_evt
);
    bus_lines_t raw_lines;
    bus_lines_t cur_lines;
    bus_lines_t prev_lines;
    logic       start_pulse;
    logic       stop_pulse;
    logic       bus_busy;
    logic       stop_ok;
    evt_stat_t  flags;

    assign raw_lines.scl = scl_in;
    assign raw_lines.sda = sda_in;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (raw_lines),
        .cur  (cur_lines),
        .prev (prev_lines)
    );

    i2c_cond_detect u_det (
        .clk         (clk),
        .rst         (rst),
        .cur         (cur_lines),
        .prev        (prev_lines),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .bus_busy    (bus_busy)
    );

    i2c_stop_qual u_qual (
        .clk                 (clk),
        .rst                 (rst),
        .stop_pulse          (stop_pulse),
        .sar_match           (sar_match),
        .master_mode         (master_mode),
        .master_active       (master_active),
        .cfg_stop_if_addr    (cfg_stop_if_addr),
        .cfg_stop_if_mst_act (cfg_stop_if_mst_act),
        .stop_ok             (stop_ok)
    );

    i2c_evt_flags u_flags (
        .clk             (clk),
        .rst             (rst),
        .start_pulse     (start_pulse),
        .stop_ok         (stop_ok),
        .bus_busy        (bus_busy),
        .slv_tx_nack     (slv_tx_nack),
        .ctl_enable      (ctl_enable),
        .rd_clr_activity (rd_clr_activity),
        .rd_clr_intr     (rd_clr_intr),
        .flags           (flags)
    );

    assign raw_evt[BIT_START] = flags.start;
    assign raw_evt[BIT_STOP]  = flags.stop;
    assign raw_evt[BIT_ACT]   = flags.activity;
    assign raw_evt[BIT_DONE]  = flags.done;
endmodule

// File: rtl/i2c_bus_evt_chk.sv
module i2c_bus_evt_chk (
    input logic        clk,
    input logic        rst,
    input logic        ctl_enable,
    input logic        master_mode,
    input logic        master_active,
    input logic        slv_tx_nack,
    input logic        cfg_stop_if_mst_act,
    input logic        rd_clr_activity,
    input logic        rd_clr_intr,
    input logic        start_pulse,
    input logic        stop_pulse,
    input logic [10:7] raw_evt
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> raw_evt == 4'b0000); // R1

    AST_START_FLAGS: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> raw_evt[10]); // R2

    AST_MST_STOP_GATED: assert property (@(posedge clk) disable iff (rst)
        stop_pulse && master_mode && cfg_stop_if_mst_act && !master_active
        && !raw_evt[9] |=> !raw_evt[9]); // R6

    AST_ACT_STICKY: assert property (@(posedge clk) disable iff (rst)
        raw_evt[8] && ctl_enable && !rd_clr_activity && !rd_clr_intr |=> raw_evt[8]); // R7

    AST_DISABLE_DROPS_ACT: assert property (@(posedge clk) disable iff (rst)
        !ctl_enable |=> !raw_evt[8]); // R8

    AST_DONE_ON_NACK: assert property (@(posedge clk) disable iff (rst)
        slv_tx_nack |=> raw_evt[7]); // R9

    AST_CLR_DONE: assert property (@(posedge clk) disable iff (rst)
        rd_clr_intr && !slv_tx_nack |=> !raw_evt[7]); // R10
endmodule

bind i2c_bus_evt_status i2c_bus_evt_chk u_chk (
    .clk                 (clk),
    .rst                 (rst),
    .ctl_enable          (ctl_enable),
    .master_mode         (master_mode),
    .master_active       (master_active),
    .slv_tx_nack         (slv_tx_nack),
    .cfg_stop_if_mst_act (cfg_stop_if_mst_act),
    .rd_clr_activity     (rd_clr_activity),
    .rd_clr_intr         (rd_clr_intr),
    .start_pulse         (start_pulse),
    .stop_pulse          (stop_pulse),
    .raw_evt             (raw_evt)
);

// File: tb/sim_i2c_bus_evt_status.sv
`timescale 1ns/1ps
module sim_i2c_bus_evt_status;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_in = 1'b1;
    logic        sda_in = 1'b1;
    logic        ctl_enable = 1'b1;
    logic        master_mode = 1'b0;
    logic        sar_match = 1'b0;
    logic        master_active = 1'b0;
    logic        slv_tx_nack = 1'b0;
    logic        cfg_stop_if_addr = 1'b0;
    logic        cfg_stop_if_mst_act = 1'b0;
    logic        rd_clr_activity = 1'b0;
    logic        rd_clr_intr = 1'b0;
    logic [10:7] raw_evt;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    i2c_bus_evt_status u0 (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .ctl_enable(ctl_enable), .master_mode(master_mode),
        .sar_match(sar_match), .master_active(master_active),
        .slv_tx_nack(slv_tx_nack), .cfg_stop_if_addr(cfg_stop_if_addr),
        .cfg_stop_if_mst_act(cfg_stop_if_mst_act),
        .rd_clr_activity(rd_clr_activity), .rd_clr_intr(rd_clr_intr),
        .raw_evt(raw_evt)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic bus_start();
        scl_in = 1'b1; sda_in = 1'b1; step(4);
        sda_in = 1'b0; step(4);
        scl_in = 1'b0; step(4);
    endtask

    task automatic bus_stop();
        scl_in = 1'b0; step(2);
        sda_in = 1'b0; step(4);
        scl_in = 1'b1; step(4);
        sda_in = 1'b1; step(4);
    endtask

    task automatic pulse_clr_intr();
        rd_clr_intr = 1'b1; step(1); rd_clr_intr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; step(3); rst = 1'b0;
        check("R1 reset", raw_evt, 4'b0000);
    endtask

    task automatic t_start();
        scl_in = 1'b1; sda_in = 1'b1; step(4);
        sda_in = 1'b0;
        step(2);
        check("R2 start early", {3'b000, raw_evt[10]}, 4'b0000);
        step(1);
        check("R2 start due", {3'b000, raw_evt[10]}, 4'b0001);
        check("R7 act on start", {3'b000, raw_evt[8]}, 4'b0001);
        scl_in = 1'b0; step(4);
        pulse_clr_intr();
        check("R10 start cleared", {3'b000, raw_evt[10]}, 4'b0000);
        sda_in = 1'b1; step(2);
        scl_in = 1'b1; step(4);
        sda_in = 1'b0; step(4);
        check("R2 repeated start", {3'b000, raw_evt[10]}, 4'b0001);
        scl_in = 1'b0; step(4);
    endtask

    task automatic t_scl_low();
        pulse_clr_intr();
        scl_in = 1'b0;
        sda_in = 1'b1; step(4);
        sda_in = 1'b0; step(4);
        sda_in = 1'b1; step(4);
        check("R3 no start/stop with scl low", {2'b00, raw_evt[10], raw_evt[9]}, 4'b0000);
        sda_in = 1'b0; step(2);
        bus_stop();
    endtask

    task automatic t_stop_addr();
        master_mode = 1'b0; cfg_stop_if_addr = 1'b1;
        pulse_clr_intr();
        bus_start();
        bus_stop();
        check("R4 unaddressed stop", {3'b000, raw_evt[9]}, 4'b0000);
        bus_start();
        sar_match = 1'b1; step(1); sar_match = 1'b0;
        bus_stop();
        check("R4 addressed stop", {3'b000, raw_evt[9]}, 4'b0001);
        pulse_clr_intr();
        bus_start();
        bus_stop();
        check("R4 address cleared by stop", {3'b000, raw_evt[9]}, 4'b0000);
    endtask

    task automatic t_stop_any();
        master_mode = 1'b0; cfg_stop_if_addr = 1'b0;
        pulse_clr_intr();
        bus_start();
        bus_stop();
        check("R5 any stop", {3'b000, raw_evt[9]}, 4'b0001);
    endtask

    task automatic t_stop_master();
        master_mode = 1'b1; cfg_stop_if_mst_act = 1'b1; master_active = 1'b0;
        cfg_stop_if_addr = 1'b1;
        pulse_clr_intr();
        bus_start(); bus_stop();
        check("R6 inactive master", {3'b000, raw_evt[9]}, 4'b0000);
        master_active = 1'b1;
        bus_start(); bus_stop();
        check("R6 active master", {3'b000, raw_evt[9]}, 4'b0001);
        pulse_clr_intr();
        cfg_stop_if_mst_act = 1'b0; master_active = 1'b0;
        bus_start(); bus_stop();
        check("R6 unqualified master", {3'b000, raw_evt[9]}, 4'b0001);
        master_mode = 1'b0; cfg_stop_if_addr = 1'b0;
    endtask

    task automatic t_activity();
        bus_start(); bus_stop();
        step(10);
        check("R7 sticky when idle", {3'b000, raw_evt[8]}, 4'b0001);
        rd_clr_activity = 1'b1; step(1); rd_clr_activity = 1'b0;
        check("R8 clr_activity", raw_evt, 4'b1100);
        bus_start(); bus_stop();
        pulse_clr_intr();
        check("R8 clr_intr clears act", {3'b000, raw_evt[8]}, 4'b0000);
        bus_start(); bus_stop();
        ctl_enable = 1'b0; step(1);
        check("R8 disable clears act", {3'b000, raw_evt[8]}, 4'b0000);
        ctl_enable = 1'b1; step(3);
        check("R8 stays clear after enable", {3'b000, raw_evt[8]}, 4'b0000);
    endtask

    task automatic t_done();
        pulse_clr_intr();
        slv_tx_nack = 1'b1; step(1); slv_tx_nack = 1'b0;
        check("R9 done set", {3'b000, raw_evt[7]}, 4'b0001);
        slv_tx_nack = 1'b1; rd_clr_intr = 1'b1; step(1);
        slv_tx_nack = 1'b0; rd_clr_intr = 1'b0;
        check("R10 event wins", {3'b000, raw_evt[7]}, 4'b0001);
        pulse_clr_intr();
        check("R10 done cleared", raw_evt, 4'b0000);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_start();
        t_scl_low();
        t_stop_addr();
        t_stop_any();
        t_stop_master();
        t_activity();
        t_done();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule